// File: doc/BRIEF.md
# Frame Sync Rate and Integrity Monitor

This block sits beside a reference clock input that comes with a companion frame sync pulse. It runs on the reference clock itself. For every interval between two sync pulses it counts the reference cycles, and it uses that count to do two things. It works out whether the sync train runs at 8 kHz or at 2 kHz, and it decides whether the sync can be trusted. The two valid counts come from a configured nominal reference rate given in kHz. With a 2048 kHz reference, a valid 8 kHz interval holds 256 cycles and a valid 2 kHz interval holds 1024 cycles.

When the sync goes bad, or stops arriving, the block raises a fail flag. When this clock and sync pair is the one selected, a downstream phase-locked loop is told to stop aligning its output frame pulse to the sync and to lock to the clock alone. Frame alignment comes back only after the sync has shown two correct intervals in a row.

Top module: `sync_ratio_monitor`

## Requirements
- R1: The sync input passes through a two-flop synchronizer clocked by the reference clock. Each rising edge of the synchronized sync closes one interval and opens the next. The interval length is the number of reference cycles between two successive rising edges.
- R2: The two valid interval lengths are `ref_rate_khz / 8` for an 8 kHz sync and `ref_rate_khz / 2` for a 2 kHz sync. At 2048 kHz these are 256 and 1024.
- R3: An interval equal to the 8 kHz length sets `rate_8k` to 1. An interval equal to the 2 kHz length sets it to 0. After reset `rate_8k` is 0.
- R4: An interval that matches neither valid length sets `sync_fail` to 1 and `sync_ok` to 0, and leaves `rate_8k` unchanged.
- R5: `sync_ok` and `sync_fail` are never both 1.
- R6: The limit is the 2 kHz length plus 4. If the cycle count since the last edge goes past this limit with no new edge, `sync_fail` rises and the counter holds at the limit plus one. This also applies before the first edge after reset.
- R7: Once `sync_fail` is 1, it clears and `sync_ok` sets only after two consecutive intervals of valid length. A single valid interval leaves the block in failure.
- R8: After reset, `sync_ok`, `sync_fail` and `align_en` are 0. The first edge after reset only opens an interval. If no failure has occurred, the first interval checked with a valid length sets `sync_ok`.
- R9: `align_en` is 1 exactly when `pair_sel` is 1 and `sync_ok` is 1. It therefore drops whenever the sync has failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, also the counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in | input | 1 | Frame sync pulse belonging to the reference |
| ref_rate_khz | input | RATE_W | Nominal reference frequency in kHz (multiple of 8) |
| pair_sel | input | 1 | High when this reference and sync pair is selected |
| rate_8k | output | 1 | 1: sync classified as 8 kHz, 0: as 2 kHz |
| sync_ok | output | 1 | Sync interval count judged correct |
| sync_fail | output | 1 | Sync judged bad or missing |
| align_en | output | 1 | Tells the loop to align its frame pulse to the sync |

## Verification
The main test feeds a 64 kHz nominal rate, so the valid intervals are 8 and 32 cycles. Random sequences mix these valid intervals with intervals that are off by one or two cycles, or far off. This separates an exact-match classifier from one that tolerates error, and it shows whether the rate flag stays put on a bad interval. Directed runs cover three cases: a long silence, which exercises the timeout and saturation path; a single good interval after a failure, which shows whether recovery waits for two; and a silence straight after reset. A separate run at 2048 kHz confirms the 256 and 1024 cycle counts.

// File: rtl/srm_pkg.sv
package srm_pkg;

  // Cycles past the 2 kHz count that are tolerated before a missing sync is declared
  localparam int unsigned SRM_MARGIN = 4;

  typedef enum logic [1:0] {
    PER_NONE = 2'd0,
    PER_GOOD = 2'd1,
    PER_BAD  = 2'd2
  } per_class_e;

  function automatic int unsigned srm_len_8k(input int unsigned rate_khz);
    return rate_khz / 8;
  endfunction

  function automatic int unsigned srm_len_2k(input int unsigned rate_khz);
    return rate_khz / 2;
  endfunction

endpackage

// File: rtl/srm_sync2.sv
module srm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;
endmodule

// File: rtl/srm_period_cnt.sv
module srm_period_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_s,
  input  logic [CNT_W-1:0] limit,
  output logic             period_done,
  output logic [CNT_W-1:0] period_len,
  output logic             timeout
);
  logic             prev_q;
  logic             started_q, started_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             edge_p;
  logic             at_limit;

  assign edge_p   = sync_s & ~prev_q;
  assign at_limit = (cnt_q == limit);

  always_comb begin
    started_d = started_q;
    cnt_d     = cnt_q;
    if (edge_p) begin
      started_d = 1'b1;
      cnt_d     = {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (!at_limit) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      prev_q    <= sync_s;
      started_q <= started_d;
      cnt_q     <= cnt_d;
    end
  end

  assign period_done = edge_p & started_q;
  assign period_len  = cnt_q;
  assign timeout     = ~edge_p & (cnt_q == limit - 1'b1);

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit) else $error("counter beyond limit"); // R6

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && !edge_p) |=> (cnt_q == $past(cnt_q))) else $error("counter not held"); // R6
endmodule

// File: rtl/srm_verdict.sv
module srm_verdict #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_done,
  input  logic [CNT_W-1:0] period_len,
  input  logic [CNT_W-1:0] len_8k,
  input  logic [CNT_W-1:0] len_2k,
  input  logic             timeout,
  output logic             ok,
  output logic             fail,
  output logic             rate_8k
);
  import srm_pkg::*;

  per_class_e cls;
  logic       ok_q, ok_d;
  logic       fail_q, fail_d;
  logic       rate_q, rate_d;
  logic       run_q, run_d;

  always_comb begin
    cls = PER_NONE;
    if (period_done) begin
      if ((period_len == len_8k) || (period_len == len_2k)) cls = PER_GOOD;
      else                                                 cls = PER_BAD;
    end
  end

  always_comb begin
    ok_d   = ok_q;
    fail_d = fail_q;
    rate_d = rate_q;
    run_d  = run_q;
    if (timeout || cls == PER_BAD) begin
      ok_d   = 1'b0;
      fail_d = 1'b1;
      run_d  = 1'b0;
    end else if (cls == PER_GOOD) begin
      rate_d = (period_len == len_8k);
      if (fail_q) begin
        if (run_q) begin
          fail_d = 1'b0;
          ok_d   = 1'b1;
          run_d  = 1'b0;
        end else begin
          run_d = 1'b1;
        end
      end else begin
        ok_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
      rate_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      ok_q   <= ok_d;
      fail_q <= fail_d;
      rate_q <= rate_d;
      run_q  <= run_d;
    end
  end

  assign ok      = ok_q;
  assign fail    = fail_q;
  assign rate_8k = rate_q;

  AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && fail_q)) else $error("ok and fail together"); // R5

  AST_RATE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == PER_BAD) |=> $stable(rate_q)) else $error("rate moved on bad period"); // R4

  AST_TIMEOUT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (fail_q && !ok_q)) else $error("timeout not flagged"); // R6

  AST_ONE_GOOD_NOT_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !run_q && cls == PER_GOOD) |=> fail_q) else $error("recovered too early"); // R7
endmodule

// File: rtl/sync_ratio_monitor.sv
module sync_ratio_monitor #(
  parameter int RATE_W = 12
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic [RATE_W-1:0] ref_rate_khz,
  input  logic              pair_sel,
  output logic              rate_8k,
  output logic              sync_ok,
  output logic              sync_fail,
  output logic              align_en
);
  import srm_pkg::*;

  localparam int CNT_W = RATE_W;

  logic             rst_n_s;
  logic             sync_s;
  logic [CNT_W-1:0] len_8k, len_2k, limit;
  logic             period_done, timeout;
  logic [CNT_W-1:0] period_len;

  assign len_8k = CNT_W'(srm_len_8k(int'(ref_rate_khz)));
  assign len_2k = CNT_W'(srm_len_2k(int'(ref_rate_khz)));
  assign limit  = len_2k + CNT_W'(SRM_MARGIN + 1);

  srm_sync2 u_rst_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .din   (1'b1),
    .dout  (rst_n_s)
  );

  srm_sync2 u_pulse_sync (
    .clk   (clk_ref),
    .rst_n (rst_n_s),
    .din   (sync_in),
    .dout  (sync_s)
  );

  srm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk_ref),
    .rst_n       (rst_n_s),
    .sync_s      (sync_s),
    .limit       (limit),
    .period_done (period_done),
    .period_len  (period_len),
    .timeout     (timeout)
  );

  srm_verdict #(.CNT_W(CNT_W)) u_verdict (
    .clk         (clk_ref),
    .rst_n       (rst_n_s),
    .period_done (period_done),
    .period_len  (period_len),
    .len_8k      (len_8k),
    .len_2k      (len_2k),
    .timeout     (timeout),
    .ok          (sync_ok),
    .fail        (sync_fail),
    .rate_8k     (rate_8k)
  );

  assign align_en = pair_sel & sync_ok;

  AST_ALIGN_DROP: assert property (@(posedge clk_ref) disable iff (!rst_n_s)
    sync_fail |-> !align_en) else $error("alignment kept on failure"); // R9
endmodule

// File: tb/sync_ratio_monitor_tb.sv
`timescale 1ns/1ps
module sync_ratio_monitor_tb_top;
  localparam int RATE_W = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sync_in;
  logic [RATE_W-1:0] ref_rate_khz;
  logic              pair_sel;
  logic              rate_8k, sync_ok, sync_fail, align_en;

  int checks = 0;
  int errors = 0;
  bit m_started, m_ok, m_fail, m_run, m_rate8;
  int last_gap;
  int rate_cfg;

  always #10 clk = ~clk;

  sync_ratio_monitor #(.RATE_W(RATE_W)) dut_i (
    .clk_ref      (clk),
    .rst_n        (rst_n),
    .sync_in      (sync_in),
    .ref_rate_khz (ref_rate_khz),
    .pair_sel     (pair_sel),
    .rate_8k      (rate_8k),
    .sync_ok      (sync_ok),
    .sync_fail    (sync_fail),
    .align_en     (align_en)
  );

  function automatic int len8(input int r); return r / 8; endfunction
  function automatic int len2(input int r); return r / 2; endfunction
  function automatic int lim(input int r);  return r / 2 + 5; endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag,  "sync_ok",   sync_ok,   m_ok);
    chk(tag,  "sync_fail", sync_fail, m_fail);
    chk("R3", "rate_8k",   rate_8k,   m_rate8);
    chk("R9", "align_en",  align_en,  pair_sel & m_ok);
    chk("R5", "ok_and_fail", sync_ok & sync_fail, 1'b0);
  endtask

  task automatic model_interval(input int gap);
    bit good;
    if (!m_started) begin
      m_started = 1'b1;
      return;
    end
    good = (gap == len8(rate_cfg)) || (gap == len2(rate_cfg));
    if (good) begin
      m_rate8 = (gap == len8(rate_cfg));
      if (m_fail) begin
        if (m_run) begin m_fail = 0; m_ok = 1; m_run = 0; end
        else m_run = 1;
      end else m_ok = 1;
    end else begin
      m_ok = 0; m_fail = 1; m_run = 0;
    end
  endtask

  task automatic do_reset(input int rate);
    @(negedge clk);
    rst_n = 1'b0;
    sync_in = 1'b0;
    rate_cfg = rate;
    ref_rate_khz = RATE_W'(rate);
    m_started = 0; m_ok = 0; m_fail = 0; m_run = 0; m_rate8 = 0;
    last_gap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One rising sync edge, then n cycles until the next call rises
  task automatic tick(input int n, input string tag);
    @(negedge clk);
    sync_in = 1'b1;
    model_interval(last_gap);
    last_gap = n;
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      if (k == 2) sync_in = 1'b0;
      if (k == 6) check_all(tag);
      if (n >= lim(rate_cfg) + 8 && k == lim(rate_cfg) + 8) begin
        m_ok = 0; m_fail = 1; m_run = 0;
        chk("R6", "timeout_fail", sync_fail, 1'b1);
        chk("R6", "timeout_ok",   sync_ok,   1'b0);
        chk("R9", "timeout_align", align_en, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int gaps [10];
    gaps = '{8, 8, 8, 32, 32, 7, 9, 30, 33, 20};
    void'($urandom(32'h5eed));
    pair_sel = 1'b1;
    rst_n = 1'b0;
    sync_in = 1'b0;
    ref_rate_khz = '0;

    // R8: reset state
    do_reset(64);
    chk("R8", "reset_ok",    sync_ok,   1'b0);
    chk("R8", "reset_fail",  sync_fail, 1'b0);
    chk("R8", "reset_rate",  rate_8k,   1'b0);
    chk("R8", "reset_align", align_en,  1'b0);

    // R8 / R3: first intervals at 8 kHz, then 2 kHz
    for (int i = 0; i < 4; i++) tick(8, "R8");
    for (int i = 0; i < 3; i++) tick(32, "R3");
    tick(8, "R3");

    // R4 then R7: one bad interval, then recovery needing two good ones
    tick(9, "R4");
    tick(32, "R4");
    tick(8, "R7");
    tick(8, "R7");
    tick(8, "R7");

    // R6: silence beyond the limit
    tick(60, "R6");
    tick(8, "R6");
    tick(8, "R7");
    tick(8, "R7");
    tick(8, "R7");

    // R1 / R4: random interval mix
    for (int i = 0; i < 150; i++) begin
      pair_sel = ($urandom % 4) != 0;
      tick(gaps[$urandom % 10], "R1");
    end
    pair_sel = 1'b1;

    // R6: no edge at all after reset
    do_reset(64);
    repeat (lim(64) + 8) @(negedge clk);
    m_fail = 1;
    chk("R6", "silent_reset_fail", sync_fail, 1'b1);
    chk("R6", "silent_reset_ok",   sync_ok,   1'b0);
    for (int i = 0; i < 4; i++) tick(8, "R7");

    // R2: full 2048 kHz rate, 256 and 1024 cycle intervals
    do_reset(2048);
    for (int i = 0; i < 3; i++) tick(256, "R2");
    for (int i = 0; i < 3; i++) tick(1024, "R2");
    tick(256, "R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule